// File: doc/BRIEF.md
# Shared-Multiplier Eight-Band Audio Filter Bank

The block splits a mono audio stream into eight frequency bands for a level display. Each band is a 32-tap band-pass FIR filter, but a single multiply-accumulate path does the work for all of them. For every accepted input sample, a sequencer sweeps the bands one after another, lowest band first. It reads taps from a shared 32-entry sample history and coefficients from an internal ROM. It then emits one saturated result per band, tagged with its band index. The nominal bands, from band 0 upward, are 10-100 Hz, 100-300 Hz, 300-600 Hz, 600 Hz-1.2 kHz, 1.2-2.4 kHz, 2.4-4.8 kHz, 4.8-9.6 kHz and 9.6-20 kHz.

At about 44 kHz input and an 83.33 MHz clock there are roughly 1890 clocks per sample. A full sweep takes 8 x 34 = 272 clocks, so it fits comfortably in that window. The latest result of each band is held in a register, and a combinational read port makes those registers available to a host.

Top module: `mband_fir_bank`

## Requirements
- R1: While rst_ni is low and after its release, every band result reads 0 and done_o, out_valid_o, busy_o and overrun_o are 0. Every history entry is 0, so samples older than the first accepted one count as 0.
- R2: A sample is taken at a rising edge where smp_valid_i is 1 and busy_o is 0. busy_o is 1 from the next cycle until the sweep ends.
- R3: When smp_valid_i is 1 at an edge where busy_o is 1, the sample is discarded and leaves no trace in any band result. overrun_o goes to 1 after that edge and stays 1 until reset.
- R4: After an accepting edge E, out_valid_o is a one-cycle pulse in the cycle after edge E+34*(b+1), with out_band_o = b, for b = 0..7 in rising order. It is 0 in all other cycles of the sweep.
- R5: The result of band b is y_b = sat16(floor(S_b / 2^15)), where S_b = sum over t = 0..31 of x[t]*c[b][t]. Here x[t] is the sample accepted t samples before the newest one, and x[0] is the newest. Samples and coefficients are 16-bit two's complement, and S_b is exact in a 40-bit accumulator.
- R6: The coefficient c[b][t] is the low 16 bits of 40503*(32*b+t+1), read as a signed value.
- R7: sat16 clamps to the range -32768..32767.
- R8: done_o is 1 for exactly the cycle in which band 7 is reported, and busy_o is 0 in that same cycle.
- R9: rd_data_o shows the latest result of band rd_band_i without delay. It keeps that value until a later sweep rewrites the band.
- R10: The history keeps exactly the 32 most recent accepted samples. A sample leaves the sum once 32 newer samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 16 | Signed input sample |
| rd_band_i | input | 3 | Band selected for the read port |
| rd_data_o | output | 16 | Latest result of the selected band |
| out_valid_o | output | 1 | Band result pulse |
| out_band_o | output | 3 | Index of the reported band |
| out_data_o | output | 16 | Reported band result |
| done_o | output | 1 | Sweep complete pulse |
| busy_o | output | 1 | Sweep in progress |
| overrun_o | output | 1 | Sticky flag for a dropped sample |

## Verification
The assertions assume that smp_valid_i and smp_data_i change only between clock edges and are never unknown after reset. The bench drives every input on the falling edge. Samples are normally presented only while busy_o is low. In one deliberate case the bench raises smp_valid_i mid-sweep to provoke an overrun, and it compares the following band results against a model that ignores that sample.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  localparam int unsigned MFB_COEF_MULT = 40503;

  typedef enum logic [1:0] {
    MAC_HOLD  = 2'd0,
    MAC_LOAD  = 2'd1,
    MAC_ADD   = 2'd2
  } mac_op_e;
endpackage

// File: rtl/mfb_history.sv
module mfb_history #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 32,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic signed [DATA_W-1:0] din_i,
  input  logic [TAP_W-1:0]         tap_i,
  output logic signed [DATA_W-1:0] dout_o
);
  logic signed [DATA_W-1:0] mem_q [TAPS];
  logic [TAP_W-1:0] head_q;
  logic [TAP_W-1:0] head_nx;
  logic [TAP_W-1:0] rd_idx;

  assign head_nx = head_q + 1'b1;
  assign rd_idx  = head_q - tap_i;   // tap 0 = newest
  assign dout_o  = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      head_q         <= head_nx;
      mem_q[head_nx] <= din_i;
    end
  end

  assert_newest_written_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[head_q] == $past(din_i));
endmodule

// File: rtl/mfb_coef_rom.sv
module mfb_coef_rom #(
  parameter int COEF_W = 16,
  parameter int BANDS  = 8,
  parameter int TAPS   = 32,
  localparam int BAND_W = $clog2(BANDS),
  localparam int TAP_W  = $clog2(TAPS),
  localparam int DEPTH  = BANDS * TAPS
) (
  input  logic [BAND_W-1:0]        band_i,
  input  logic [TAP_W-1:0]         tap_i,
  output logic signed [COEF_W-1:0] coef_o
);
  logic [COEF_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [31:0] PROD = 32'(mfb_pkg::MFB_COEF_MULT * (g + 1));
    assign rom[g] = PROD[COEF_W-1:0];
  end

  assign coef_o = $signed(rom[{band_i, tap_i}]);
endmodule

// File: rtl/mfb_sequencer.sv
module mfb_sequencer #(
  parameter int BANDS = 8,
  parameter int TAPS  = 32,
  localparam int BAND_W = $clog2(BANDS),
  localparam int TAP_W  = $clog2(TAPS),
  localparam int LAST   = TAPS + 1,
  localparam int CNT_W  = $clog2(TAPS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [BAND_W-1:0] band_o,
  output logic [TAP_W-1:0]  tap_o,
  output mfb_pkg::mac_op_e  mac_op_o,
  output logic              wr_o,
  output logic              last_band_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BAND_W-1:0] band_q;
  logic              busy_q;

  assign busy_o      = busy_q;
  assign band_o      = band_q;
  assign tap_o       = cnt_q[TAP_W-1:0];
  assign wr_o        = busy_q && (cnt_q == CNT_W'(LAST));
  assign last_band_o = band_q == BAND_W'(BANDS - 1);

  always_comb begin
    mac_op_o = mfb_pkg::MAC_HOLD;
    if (busy_q && cnt_q == CNT_W'(1))
      mac_op_o = mfb_pkg::MAC_LOAD;  // clear at band start
    else if (busy_q && cnt_q > CNT_W'(1) && cnt_q <= CNT_W'(TAPS))
      mac_op_o = mfb_pkg::MAC_ADD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      band_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      band_q <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(LAST)) begin
        cnt_q <= '0;
        if (last_band_o) busy_q <= 1'b0;
        else             band_q <= band_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CNT_W'(LAST));
  assert_start_band0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && band_q == '0 && cnt_q == '0);
endmodule

// File: rtl/mfb_mac.sv
module mfb_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  mfb_pkg::mac_op_e         op_i,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [PROD_W-1:0] prod_q;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
  assign acc_o    = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      prod_q <= smp_i * coef_i;
      case (op_i)
        mfb_pkg::MAC_LOAD: acc_q <= prod_ext;
        mfb_pkg::MAC_ADD:  acc_q <= acc_q + prod_ext;
        default:           acc_q <= acc_q;
      endcase
    end
  end

  assert_load_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == mfb_pkg::MAC_LOAD |=> acc_q == $past(prod_ext));
endmodule

// File: rtl/mband_fir_bank.sv
module mband_fir_bank #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC   = 15,
  parameter int BANDS  = 8,
  parameter int TAPS   = 32,
  localparam int BAND_W = $clog2(BANDS),
  localparam int TAP_W  = $clog2(TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [BAND_W-1:0] rd_band_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              out_valid_o,
  output logic [BAND_W-1:0] out_band_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              overrun_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  logic                     accept;
  logic                     busy;
  logic [BAND_W-1:0]        band;
  logic [TAP_W-1:0]         tap;
  mfb_pkg::mac_op_e         mac_op;
  logic                     wr_band;
  logic                     last_band;
  logic signed [DATA_W-1:0] hist_smp;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0]        sat_val;
  logic [DATA_W-1:0]        res_q [BANDS];

  assign accept = smp_valid_i && !busy;
  assign busy_o = busy;

  mfb_history #(.DATA_W(DATA_W), .TAPS(TAPS)) hist_i (
    .clk_i, .rst_ni, .we_i(accept), .din_i($signed(smp_data_i)),
    .tap_i(tap), .dout_o(hist_smp));

  mfb_coef_rom #(.COEF_W(COEF_W), .BANDS(BANDS), .TAPS(TAPS)) rom_i (
    .band_i(band), .tap_i(tap), .coef_o(coef));

  mfb_sequencer #(.BANDS(BANDS), .TAPS(TAPS)) seq_i (
    .clk_i, .rst_ni, .start_i(accept), .busy_o(busy), .band_o(band),
    .tap_o(tap), .mac_op_o(mac_op), .wr_o(wr_band), .last_band_o(last_band));

  mfb_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) mac_i (
    .clk_i, .rst_ni, .smp_i(hist_smp), .coef_i(coef), .op_i(mac_op), .acc_o(acc));

  always_comb begin
    shifted = acc >>> FRAC;
    if (shifted > SAT_HI)      sat_val = SAT_HI[DATA_W-1:0];
    else if (shifted < SAT_LO) sat_val = SAT_LO[DATA_W-1:0];
    else                       sat_val = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_band_o  <= '0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
      overrun_o   <= 1'b0;
      for (int i = 0; i < BANDS; i++) res_q[i] <= '0;
    end else begin
      out_valid_o <= wr_band;
      done_o      <= wr_band && last_band;
      if (smp_valid_i && busy) overrun_o <= 1'b1;
      if (wr_band) begin
        out_band_o  <= band;
        out_data_o  <= sat_val;
        res_q[band] <= sat_val;
      end
    end
  end

  assign rd_data_o = res_q[rd_band_i];

  assert_overrun_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && busy |=> overrun_o);
  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  assert_done_with_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o && out_band_o == BAND_W'(BANDS - 1) && !busy);
  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  assert_result_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o == res_q[out_band_o]);
endmodule

// File: tb/mband_fir_bank_tb_top.sv
module mband_fir_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int NT = 32;
  localparam int SWEEP = 272;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [2:0]  rd_band = '0;
  logic [15:0] rd_data;
  logic        out_valid;
  logic [2:0]  out_band;
  logic [15:0] out_data;
  logic        done;
  logic        busy;
  logic        overrun;

  int checks = 0;
  int failures = 0;
  logic signed [15:0] hist_m [NT];
  logic [15:0] exp_res [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  mband_fir_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .rd_band_i(rd_band), .rd_data_o(rd_data), .out_valid_o(out_valid),
    .out_band_o(out_band), .out_data_o(out_data), .done_o(done),
    .busy_o(busy), .overrun_o(overrun));

  function automatic logic signed [15:0] coef_m(int b, int t);
    logic [31:0] m;
    m = 32'(40503 * (32 * b + t + 1));
    return $signed(m[15:0]);
  endfunction

  function automatic logic [15:0] band_m(int b);
    longint s = 0;
    for (int t = 0; t < NT; t++) s += longint'(hist_m[t]) * longint'(coef_m(b, t));
    s = s >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NT; i++) hist_m[i] = '0;
    for (int b = 0; b < NB; b++) exp_res[b] = '0;
  endtask

  task automatic check_regs(string req);
    for (int b = 0; b < NB; b++) begin
      rd_band = 3'(b);
      #1;
      chk(req, 32'(rd_data), 32'(exp_res[b]));
    end
  endtask

  // inj > 0: raise a sample mid-sweep at that cycle
  task automatic sweep(logic [15:0] x, int inj);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = x;
    @(posedge clk);
    for (int i = NT - 1; i > 0; i--) hist_m[i] = hist_m[i-1];
    hist_m[0] = $signed(x);
    for (int b = 0; b < NB; b++) exp_res[b] = band_m(b);
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R2 busy after accept", 32'(busy), 32'd1);
    for (int k = 1; k <= SWEEP; k++) begin
      @(posedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
      if (k % 34 == 0) begin
        chk("R4 valid pulse", 32'(out_valid), 32'd1);
        chk("R4 band order", 32'(out_band), 32'(k / 34 - 1));
        chk("R5 band result", 32'(out_data), 32'(exp_res[k/34-1]));
      end else if (out_valid !== 1'b0) begin
        chk("R4 stray valid", 32'(out_valid), 32'd0);
      end
      if (k == SWEEP) begin
        chk("R8 done pulse", 32'(done), 32'd1);
        chk("R8 busy low at done", 32'(busy), 32'd0);
      end else if (done !== 1'b0 || busy !== 1'b1) begin
        chk("R8 done/busy mid sweep", {30'd0, done, busy}, 32'd1);
      end
      if (inj > 0 && k == inj + 1) chk("R3 overrun set", 32'(overrun), 32'd1);
      if (inj > 0 && k == inj) begin
        smp_valid = 1'b1;
        smp_data  = 16'h7abc;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seed;
    logic [15:0] r;
    seed = 32'h1f2e3d4c;
    r = 16'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset flags", {28'd0, out_valid, done, busy, overrun}, 32'd0);
    check_regs("R1 reset results");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, done, busy, overrun}, 32'd0);

    // impulse on zero history
    sweep(16'h7fff, 0);
    check_regs("R9 read port");
    chk("R3 no overrun yet", 32'(overrun), 32'd0);
    // saturation toward both rails
    for (int i = 0; i < 3; i++) sweep(16'h7fff, 0);
    for (int i = 0; i < 3; i++) sweep(16'h8000, 0);
    check_regs("R7 saturated results");
    // random fill past the history depth
    for (int i = 0; i < 40; i++) sweep(16'($urandom()), 0);
    check_regs("R10 wrapped history");
    // hold: read port unchanged while idle
    repeat (20) @(negedge clk);
    check_regs("R9 held results");
    // dropped sample mid-sweep
    sweep(16'($urandom()), 100);
    sweep(16'($urandom()), 5);
    check_regs("R3 dropped sample ignored");
    repeat (5) @(negedge clk);
    chk("R3 overrun sticky", 32'(overrun), 32'd1);

    // reset again: history cleared
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_regs("R1 reset clears results");
    chk("R1 overrun cleared", 32'(overrun), 32'd0);
    rst_n = 1'b1;
    sweep(16'h0123, 0);
    check_regs("R1 zero history after reset");
    for (int i = 0; i < 6; i++) sweep(16'($urandom()), 0);
    check_regs("R6 coefficients");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule